// File: doc/BRIEF.md
# Three-wire serial EEPROM word reader

This controller fetches one 16-bit word from a word-organised three-wire serial EEPROM. The host raises `start` for one clock and presents a word address, an address-length select and a pacing value. The controller then drives chip select, serial clock and serial data toward the memory, collects the reply from the memory's data output, and returns the word together with a one-clock `done` pulse.

Every transaction follows the same pin script. First chip select rises and one lead-in clock is given. Next come the start bit and the read opcode (the three bits 1, 1, 0), then the address with its most significant bit first. The data line is then pulled low for the rest of the transfer, and sixteen data clocks are given. Last, chip select drops and one trailing clock is given. Each pin state is held for a programmable number of system clocks, so a slow memory can be served from a fast clock.

Top module: `mwr_read_ctrl`

## Requirements
- R1: After reset `ee_cs`, `ee_sk`, `ee_di` and `done` are 0, and `rdata` is 0.
- R2: After the lead-in clock the controller sends 1, 1, 0 and then the address, most significant bit first. When `wide_mode`=0 the address is the 6 bits `word_addr[5:0]` and `word_addr[7:6]` are not sent. When `wide_mode`=1 it is the 8 bits `word_addr[7:0]`.
- R3: A transaction opens with `ee_cs`=1 while `ee_sk`=0 and `ee_di`=0. One full clock (high then low) follows before the first command bit.
- R4: For each sent bit, `ee_di` takes the bit while `ee_sk` is low. `ee_sk` then goes high and then low, and `ee_di` does not change while `ee_sk` is high.
- R5: Once the last address bit has been clocked, `ee_di` is 0 for the rest of the transaction.
- R6: Exactly 16 data clocks follow the address. `ee_do` is sampled at the end of each low half. The first sample becomes `rdata[15]` and the last becomes `rdata[0]`, and no extra bit is discarded for the memory's dummy zero.
- R7: After the data clocks `ee_cs` goes to 0, then one more full clock is given with `ee_cs`=0. All three memory pins are 0 at the end.
- R8: Every pin state lasts `div_cfg`+1 system clocks. The value used is the one present with the accepted `start`.
- R9: `done` is high for exactly one clock, in the cycle after the trailing clock's low half ends. `rdata` changes only in that cycle and holds otherwise.
- R10: While a transaction runs, `start`, `word_addr`, `wide_mode` and `div_cfg` have no effect on the pins or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read (accepted only when idle) |
| wide_mode | input | 1 | 0: 6-bit address, 1: 8-bit address |
| word_addr | input | 8 | Word address |
| div_cfg | input | 8 | Pin-state hold length minus one, in system clocks |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Word read by the last transaction |

## Verification
The bound checker watches properties that hold on every cycle. These are the quiet pins at reset, chip select rising with clock and data low, the data line holding steady while the serial clock is high, pins being low at `done`, the single-cycle `done` pulse, and `rdata` holding outside `done`. The exact pin script can only be shown by the bench scenarios. This covers the bit order for both address lengths, the dropped upper address bits, the hold length for several `div_cfg` values, the sixteen-sample alignment against a memory model that emits a dummy zero, and the ignoring of inputs mid-transaction. The bench compares every pin on every clock against its own step list.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_LEAD_HI,
    ST_LEAD_LO,
    ST_BIT_SET,
    ST_BIT_HI,
    ST_BIT_LO,
    ST_DI_LOW,
    ST_DAT_HI,
    ST_DAT_LO,
    ST_DESEL,
    ST_TRL_HI,
    ST_TRL_LO
  } mwr_state_e;

  localparam int unsigned MWR_CMD_W = 3;
  localparam logic [MWR_CMD_W-1:0] MWR_READ_CMD = 3'b110;
endpackage

// File: rtl/mwr_pacer.sv
module mwr_pacer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [DIV_W-1:0] div_in,
  input  logic             advance,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (accept) begin
        div_q <= div_in;
        cnt_q <= div_in;
      end else if (advance) begin
        cnt_q <= div_q;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/mwr_tx_frame.sv
module mwr_tx_frame
  import mwr_pkg::*;
#(
  parameter int unsigned ADDR_SHORT = 6,
  parameter int unsigned ADDR_LONG  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic                 wide,
  input  logic [ADDR_LONG-1:0] addr,
  input  logic                 shift,
  output logic                 bit_out,
  output logic                 empty
);
  localparam int unsigned FRAME_W = MWR_CMD_W + ADDR_LONG;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(MWR_CMD_W + ADDR_SHORT);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] short_frame;
  logic [CNT_W-1:0]   left_q;

  generate
    if (ADDR_LONG > ADDR_SHORT) begin : g_pad
      assign short_frame = {MWR_READ_CMD, addr[ADDR_SHORT-1:0],
                            {(ADDR_LONG-ADDR_SHORT){1'b0}}};
    end else begin : g_nopad
      assign short_frame = {MWR_READ_CMD, addr};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      left_q  <= '0;
    end else if (accept) begin
      frame_q <= wide ? {MWR_READ_CMD, addr} : short_frame;
      left_q  <= wide ? LEN_LONG : LEN_SHORT;
    end else if (shift && left_q != '0) begin
      frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
      left_q  <= left_q - 1'b1;
    end
  end

  assign bit_out = frame_q[FRAME_W-1];
  assign empty   = (left_q == '0);
endmodule

// File: rtl/mwr_rx_word.sv
module mwr_rx_word #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sample,
  input  logic              din,
  output logic [DATA_W-1:0] word,
  output logic              last
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (sample) begin
      sr_q  <= {sr_q[DATA_W-2:0], din};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word = sr_q;
  assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/mwr_read_ctrl.sv
module mwr_read_ctrl
  import mwr_pkg::*;
#(
  parameter int unsigned ADDR_SHORT = 6,
  parameter int unsigned ADDR_LONG  = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DIV_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 wide_mode,
  input  logic [ADDR_LONG-1:0] word_addr,
  input  logic [DIV_W-1:0]     div_cfg,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_di,
  input  logic                 ee_do,
  output logic                 done,
  output logic [DATA_W-1:0]    rdata
);
  mwr_state_e state_q, nxt;
  logic tick, accept, advance;
  logic tx_bit, tx_empty, tx_shift;
  logic rx_sample, rx_last;
  logic [DATA_W-1:0] rx_word;
  logic cs_q, sk_q, di_q, done_q;
  logic [DATA_W-1:0] rdata_q;

  assign accept    = start && (state_q == ST_IDLE);
  assign advance   = tick && (state_q != ST_IDLE);
  assign tx_shift  = advance && (state_q == ST_BIT_SET);
  assign rx_sample = advance && (state_q == ST_DAT_LO);

  mwr_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk(clk), .rst(rst), .accept(accept), .div_in(div_cfg),
    .advance(advance), .tick(tick)
  );

  mwr_tx_frame #(.ADDR_SHORT(ADDR_SHORT), .ADDR_LONG(ADDR_LONG)) u_tx (
    .clk(clk), .rst(rst), .accept(accept), .wide(wide_mode),
    .addr(word_addr), .shift(tx_shift), .bit_out(tx_bit), .empty(tx_empty)
  );

  mwr_rx_word #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .accept(accept), .sample(rx_sample),
    .din(ee_do), .word(rx_word), .last(rx_last)
  );

  always_comb begin
    nxt = state_q;
    if (state_q == ST_IDLE) begin
      if (accept) nxt = ST_SEL;
    end else if (tick) begin
      unique case (state_q)
        ST_SEL:     nxt = ST_LEAD_HI;
        ST_LEAD_HI: nxt = ST_LEAD_LO;
        ST_LEAD_LO: nxt = ST_BIT_SET;
        ST_BIT_SET: nxt = ST_BIT_HI;
        ST_BIT_HI:  nxt = ST_BIT_LO;
        ST_BIT_LO:  nxt = tx_empty ? ST_DI_LOW : ST_BIT_SET;
        ST_DI_LOW:  nxt = ST_DAT_HI;
        ST_DAT_HI:  nxt = ST_DAT_LO;
        ST_DAT_LO:  nxt = rx_last ? ST_DESEL : ST_DAT_HI;
        ST_DESEL:   nxt = ST_TRL_HI;
        ST_TRL_HI:  nxt = ST_TRL_LO;
        ST_TRL_LO:  nxt = ST_IDLE;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= nxt;
      cs_q    <= (nxt inside {ST_SEL, ST_LEAD_HI, ST_LEAD_LO, ST_BIT_SET,
                              ST_BIT_HI, ST_BIT_LO, ST_DI_LOW, ST_DAT_HI,
                              ST_DAT_LO});
      sk_q    <= (nxt inside {ST_LEAD_HI, ST_BIT_HI, ST_DAT_HI, ST_TRL_HI});
      if (nxt == ST_BIT_SET && state_q != ST_BIT_SET)
        di_q <= tx_bit;
      else if (nxt == ST_DI_LOW || nxt == ST_IDLE || nxt == ST_SEL)
        di_q <= 1'b0;
      done_q  <= advance && (state_q == ST_TRL_LO);
      if (advance && state_q == ST_TRL_LO)
        rdata_q <= rx_word;
    end
  end

  assign ee_cs = cs_q;
  assign ee_sk = sk_q;
  assign ee_di = di_q;
  assign done  = done_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/mwr_read_ctrl_chk.sv
module mwr_read_ctrl_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di,
  input logic              done,
  input logic [DATA_W-1:0] rdata
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ee_cs && !ee_sk && !ee_di && !done && rdata == '0));

  // R3
  cs_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> (!ee_sk && !ee_di));

  // R4
  di_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  // R7
  pins_low_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ee_cs && !ee_sk && !ee_di));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(rdata));
endmodule

bind mwr_read_ctrl mwr_read_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .done(done), .rdata(rdata)
);

// File: tb/mwr_read_ctrl_test.sv
`timescale 1ns/1ps
module mwr_read_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wide_mode = 1'b0;
  logic [7:0] word_addr = '0;
  logic [7:0] div_cfg = '0;
  logic ee_cs, ee_sk, ee_di, done;
  logic ee_do;
  logic [15:0] rdata;

  int total = 0;
  int bad = 0;
  logic [15:0] last_word = '0;

  always #4 clk = ~clk;

  mwr_read_ctrl uut (
    .clk(clk), .rst(rst), .start(start), .wide_mode(wide_mode),
    .word_addr(word_addr), .div_cfg(div_cfg), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do), .done(done), .rdata(rdata)
  );

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {a ^ 8'hA5, ~a} ^ 16'h3C69;
  endfunction

  // memory model: ignores clocks before a start bit, emits a dummy zero
  // after the address, then data MSB first on each rising clock
  int m_alen = 6;
  int nbit, dcnt;
  bit in_data;
  logic [10:0] rx_cmd;
  logic [15:0] m_word;
  logic m_do = 1'b0;
  assign ee_do = m_do;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      nbit = 0; dcnt = 0; in_data = 0; rx_cmd = '0; m_do = 1'b0;
    end else if (!in_data) begin
      if (nbit > 0 || ee_di) begin
        rx_cmd = {rx_cmd[9:0], ee_di};
        nbit++;
        if (nbit == 3 + m_alen) begin
          in_data = 1;
          dcnt = 0;
          m_do = 1'b0;
          if (m_alen == 8)
            m_word = (rx_cmd[10:8] == 3'b110) ? mem_word(rx_cmd[7:0]) : 16'hDEAD;
          else
            m_word = (rx_cmd[8:6] == 3'b110) ? mem_word({2'b00, rx_cmd[5:0]}) : 16'hDEAD;
        end
      end
    end else begin
      m_do = (dcnt < 16) ? m_word[15 - dcnt] : 1'b0;
      dcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R7 idle pins", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
      chk("R9 idle done/hold", {15'd0, done, rdata}, {16'd0, last_word});
    end
  endtask

  // poke_at >= 0: one cycle into the run, scramble all inputs (R10)
  task automatic run(input logic [7:0] a, input logic wide, input int div, input int poke_at);
    logic [2:0] qp[$];
    string qt[$];
    int alen;
    int cyc;
    logic [15:0] exp_w;
    logic [10:0] frame;
    alen = wide ? 8 : 6;
    frame = wide ? {3'b110, a} : {3'b110, a[5:0], 2'b00};
    exp_w = wide ? mem_word(a) : mem_word({2'b00, a[5:0]});
    qp.push_back(3'b100); qt.push_back("R3 select");
    qp.push_back(3'b110); qt.push_back("R3 lead hi");
    qp.push_back(3'b100); qt.push_back("R3 lead lo");
    for (int b = 0; b < 3 + alen; b++) begin
      logic v;
      v = frame[10 - b];
      qp.push_back({2'b10, v}); qt.push_back("R2 bit set");
      qp.push_back({2'b11, v}); qt.push_back("R4 bit hi");
      qp.push_back({2'b10, v}); qt.push_back("R4 bit lo");
    end
    qp.push_back(3'b100); qt.push_back("R5 di low");
    for (int d = 0; d < 16; d++) begin
      qp.push_back(3'b110); qt.push_back("R6 data hi");
      qp.push_back(3'b100); qt.push_back("R5 data lo");
    end
    qp.push_back(3'b000); qt.push_back("R7 deselect");
    qp.push_back(3'b010); qt.push_back("R7 trail hi");
    qp.push_back(3'b000); qt.push_back("R7 trail lo");

    m_alen = alen;
    @(negedge clk);
    start = 1'b1; word_addr = a; wide_mode = wide; div_cfg = 8'(div);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int s = 0; s < qp.size(); s++) begin
      for (int r = 0; r <= div; r++) begin
        chk(qt[s], {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, qp[s]});
        chk("R9 done low in run", {31'd0, done}, 32'd0);
        chk("R8 rdata held in run", {16'd0, rdata}, {16'd0, last_word});
        if (cyc == poke_at) begin
          start = 1'b1; word_addr = ~a; wide_mode = ~wide; div_cfg = 8'(div + 3);
        end else if (cyc == poke_at + 1) begin
          start = 1'b0;
        end
        cyc++;
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk("R9 done pulse", {31'd0, done}, 32'd1);
    chk("R6 word", {16'd0, rdata}, {16'd0, exp_w});
    chk("R7 pins low at end", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    if (poke_at >= 0) chk("R10 busy inputs ignored", {16'd0, rdata}, {16'd0, exp_w});
    last_word = exp_w;
    @(negedge clk);
    chk("R9 done single", {31'd0, done}, 32'd0);
    chk("R9 rdata holds", {16'd0, rdata}, {16'd0, exp_w});
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 pins after reset", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 rdata after reset", {16'd0, rdata}, 32'd0);
    rst = 1'b0;
    idle_check(3);
    run(8'h2D, 1'b0, 0, -1);        // R2 short address, fastest pacing
    idle_check(2);
    run(8'hFF, 1'b0, 2, -1);        // R2 upper address bits not sent
    idle_check(2);
    run(8'hA5, 1'b1, 1, -1);        // R2 long address
    run(8'h00, 1'b1, 3, -1);        // R8 slower pacing, back to back
    run(8'hFF, 1'b1, 0, -1);        // R6 all-ones address
    idle_check(1);
    run(8'h3C, 1'b1, 2, 20);        // R10 inputs scrambled mid-run
    run(8'h81, 1'b0, 5, 150);       // R10 scrambled in data phase, R8
    idle_check(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule